// File: doc/BRIEF.md
# Binary and Decimal Add/Subtract ALU

This block is the arithmetic slice of an 8-bit processor datapath. It handles add-with-carry, subtract-with-borrow and register compare. When the decimal flag is set, add and subtract also run in packed BCD mode. One more operation, AND followed by rotate right through carry, is present only because of its unusual flag rule. All results and the N, Z, V and C flags come out of one register stage, one cycle after the request.

Each request carries:
- the accumulator or register value;
- the operand;
- the current carry, decimal and overflow flags;
- a two-bit operation code.

In decimal mode the result is corrected one nibble at a time, and the flags then come from different sources:
- On add, N and Z follow the uncorrected binary sum. V is taken from the top nibble before it is corrected.
- On subtract, every flag follows the binary difference, and only the result byte is corrected.
- Compare ignores the decimal flag.

The nibble logic is generated per digit from `DATA_W`.

Top module: `bcd_addsub_alu`

## Requirements
- R1: With `op_i`=2'b00 and `decimal_i`=0, `result_o` is the low byte of `a_i + m_i + carry_i` and `c_o` is bit 8 of that sum.
- R2: On binary add, `v_o` is 1 exactly when `a_i` and `m_i` have equal bit 7 and the result's bit 7 differs from it.
- R3: On decimal add, a low-nibble sum (carry in included) above 9 has 6 added to it. The low result nibble is the low 4 bits of the corrected value, and a corrected value above 15 carries into the high nibble.
- R4: On decimal add, `v_o` uses bit 3 of the uncorrected high-nibble sum in place of the result's bit 7. After that, a high nibble above 9 has 6 added to it, and `c_o` is 1 when it then exceeds 15.
- R5: On add, in both modes, `n_o` is bit 7 and `z_o` is the zero test of the binary sum `a_i + m_i + carry_i`.
- R6: With `op_i`=2'b01, the borrow is NOT `carry_i`. The binary difference is `a_i - m_i - borrow`. `c_o` is 0 exactly when the difference borrows. `v_o` is 1 when `a_i` and `m_i` differ in bit 7 and the result's bit 7 differs from that of `a_i`.
- R7: On decimal subtract, a negative low-nibble difference has 6 subtracted from it. That nibble's borrow feeds the high nibble, and a negative high nibble also has 6 subtracted.
- R8: On subtract, `n_o`, `z_o`, `v_o` and `c_o` follow the binary difference whatever the value of `decimal_i`.
- R9: With `op_i`=2'b10, `a_i - m_i` is formed with no borrow in. N and Z come from its low byte, `c_o` is 1 when `a_i >= m_i`, `v_o` copies `overflow_i` and `result_o` is `a_i`. `decimal_i` has no effect.
- R10: With `op_i`=2'b11, `result_o` is `{carry_i, (a_i & m_i) >> 1}`. N and Z come from that result, `c_o` is its bit 6 and `v_o` is bit 6 XOR bit 5. `decimal_i` has no effect.
- R11: The outputs update one clock after a cycle with `valid_i`=1, and `valid_o` follows `valid_i` with one cycle of delay. In a cycle with `valid_i`=0 the result and flags hold their values.
- R12: While `rst_ni` is low, `result_o`, all flags and `valid_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Request strobe |
| op_i | input | 2 | 00 add, 01 subtract, 10 compare, 11 AND then rotate right |
| a_i | input | DATA_W | Accumulator or register value |
| m_i | input | DATA_W | Operand |
| carry_i | input | 1 | Carry flag in |
| decimal_i | input | 1 | Decimal mode flag |
| overflow_i | input | 1 | Overflow flag in, passed through by compare |
| result_o | output | DATA_W | Registered result |
| n_o | output | 1 | Negative flag |
| z_o | output | 1 | Zero flag |
| v_o | output | 1 | Overflow flag |
| c_o | output | 1 | Carry flag |
| valid_o | output | 1 | Result valid |

## Verification
Some rules are checked on every cycle by the assertions:
- the one-cycle valid latency and holding the outputs while idle;
- the compare rules: V passes through, the result is the register value, and carry is an unsigned greater-or-equal test;
- the rotate flags read back from the result bits;
- the binary-sum zero test on add;
- carry on binary subtract.

The remaining rules can only be shown by the bench scenarios that drive chosen operand pairs:
- the decimal nibble corrections, including the case where the decimal result is zero while Z stays clear;
- V sampled before the high-nibble correction;
- subtract flags that ignore the decimal flag.

// File: rtl/alu_pkg.sv
package alu_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_CMP = 2'd2,
    OP_ARR = 2'd3
  } alu_op_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } alu_flags_t;
endpackage

// File: rtl/bcd_add_digit.sv
module bcd_add_digit (
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic       ci_i,
  output logic [3:0] s_o,
  output logic       raw_msb_o,
  output logic       co_o
);
  logic [4:0] raw;
  logic [5:0] adj;

  always_comb begin
    raw = {1'b0, a_i} + {1'b0, b_i} + {4'b0, ci_i};
    adj = (raw > 5'd9) ? ({1'b0, raw} + 6'd6) : {1'b0, raw};
  end

  assign s_o       = adj[3:0];
  assign co_o      = adj > 6'd15;
  assign raw_msb_o = raw[3];
endmodule

// File: rtl/bcd_sub_digit.sv
module bcd_sub_digit (
  input  logic [3:0] a_i,
  input  logic [3:0] b_i,
  input  logic       bi_i,
  output logic [3:0] d_o,
  output logic       bo_o
);
  logic [4:0] diff;

  // bit 4 of the 5-bit difference marks a negative digit
  assign diff = {1'b0, a_i} - {1'b0, b_i} - {4'b0, bi_i};
  assign bo_o = diff[4];
  assign d_o  = diff[4] ? (diff[3:0] - 4'd6) : diff[3:0];
endmodule

// File: rtl/bcd_chain.sv
module bcd_chain #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] m_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              add_co_o,
  output logic              add_v_o,
  output logic [DATA_W-1:0] diff_o,
  output logic              sub_bo_o
);
  localparam int NIB_N = DATA_W / 4;

  logic [NIB_N:0] cy;
  logic [NIB_N:0] bw;
  logic           top_raw_msb;

  assign cy[0] = carry_i;
  assign bw[0] = ~carry_i;

  for (genvar i = 0; i < NIB_N; i++) begin : g_digit
    if (i == NIB_N - 1) begin : g_top
      bcd_add_digit u_add (
        .a_i       (a_i[4*i +: 4]),
        .b_i       (m_i[4*i +: 4]),
        .ci_i      (cy[i]),
        .s_o       (sum_o[4*i +: 4]),
        .raw_msb_o (top_raw_msb),
        .co_o      (cy[i+1])
      );
    end else begin : g_low
      logic msb_unused;
      bcd_add_digit u_add (
        .a_i       (a_i[4*i +: 4]),
        .b_i       (m_i[4*i +: 4]),
        .ci_i      (cy[i]),
        .s_o       (sum_o[4*i +: 4]),
        .raw_msb_o (msb_unused),
        .co_o      (cy[i+1])
      );
    end

    bcd_sub_digit u_sub (
      .a_i  (a_i[4*i +: 4]),
      .b_i  (m_i[4*i +: 4]),
      .bi_i (bw[i]),
      .d_o  (diff_o[4*i +: 4]),
      .bo_o (bw[i+1])
    );
  end

  assign add_co_o = cy[NIB_N];
  assign sub_bo_o = bw[NIB_N];
  // overflow judged on the top digit before its correction
  assign add_v_o  = ~(a_i[DATA_W-1] ^ m_i[DATA_W-1]) & (a_i[DATA_W-1] ^ top_raw_msb);
endmodule

// File: rtl/alu_core.sv
module alu_core
  import alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] m_i,
  input  logic              carry_i,
  input  logic              decimal_i,
  input  logic              overflow_i,
  output logic [DATA_W-1:0] result_o,
  output alu_flags_t        flags_o
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0]   sum_w;
  logic [DATA_W:0]   diff_w;
  logic [DATA_W:0]   cmp_w;
  logic [DATA_W-1:0] rot_w;
  logic [DATA_W-1:0] bcd_sum;
  logic [DATA_W-1:0] bcd_diff;
  logic              bcd_co;
  logic              bcd_v;
  logic              bcd_bo;

  assign sum_w  = {1'b0, a_i} + {1'b0, m_i} + {{DATA_W{1'b0}}, carry_i};
  assign diff_w = {1'b0, a_i} - {1'b0, m_i} - {{DATA_W{1'b0}}, ~carry_i};
  assign cmp_w  = {1'b0, a_i} - {1'b0, m_i};
  assign rot_w  = {carry_i, a_i[MSB:1] & m_i[MSB:1]};

  bcd_chain #(.DATA_W(DATA_W)) u_bcd (
    .a_i      (a_i),
    .m_i      (m_i),
    .carry_i  (carry_i),
    .sum_o    (bcd_sum),
    .add_co_o (bcd_co),
    .add_v_o  (bcd_v),
    .diff_o   (bcd_diff),
    .sub_bo_o (bcd_bo)
  );

  always_comb begin
    result_o = a_i;
    flags_o  = '0;
    unique case (op_i)
      OP_ADD: begin
        result_o  = decimal_i ? bcd_sum : sum_w[MSB:0];
        flags_o.n = sum_w[MSB];
        flags_o.z = (sum_w[MSB:0] == '0);
        flags_o.v = decimal_i ? bcd_v
                              : (~(a_i[MSB] ^ m_i[MSB]) & (a_i[MSB] ^ sum_w[MSB]));
        flags_o.c = decimal_i ? bcd_co : sum_w[DATA_W];
      end
      OP_SUB: begin
        result_o  = decimal_i ? bcd_diff : diff_w[MSB:0];
        flags_o.n = diff_w[MSB];
        flags_o.z = (diff_w[MSB:0] == '0);
        flags_o.v = (a_i[MSB] ^ m_i[MSB]) & (a_i[MSB] ^ diff_w[MSB]);
        // digit-chain borrow out equals the binary borrow
        flags_o.c = ~(decimal_i ? bcd_bo : diff_w[DATA_W]);
      end
      OP_CMP: begin
        result_o  = a_i;
        flags_o.n = cmp_w[MSB];
        flags_o.z = (cmp_w[MSB:0] == '0);
        flags_o.v = overflow_i;
        flags_o.c = ~cmp_w[DATA_W];
      end
      OP_ARR: begin
        result_o  = rot_w;
        flags_o.n = rot_w[MSB];
        flags_o.z = (rot_w == '0);
        flags_o.v = rot_w[MSB-1] ^ rot_w[MSB-2];
        flags_o.c = rot_w[MSB-1];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/bcd_addsub_alu.sv
module bcd_addsub_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [1:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] m_i,
  input  logic              carry_i,
  input  logic              decimal_i,
  input  logic              overflow_i,
  output logic [DATA_W-1:0] result_o,
  output logic              n_o,
  output logic              z_o,
  output logic              v_o,
  output logic              c_o,
  output logic              valid_o
);
  logic [DATA_W-1:0] res_d;
  alu_flags_t        flg_d;
  alu_flags_t        flg_q;

  alu_core #(.DATA_W(DATA_W)) u_core (
    .op_i       (alu_op_e'(op_i)),
    .a_i        (a_i),
    .m_i        (m_i),
    .carry_i    (carry_i),
    .decimal_i  (decimal_i),
    .overflow_i (overflow_i),
    .result_o   (res_d),
    .flags_o    (flg_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      result_o <= '0;
      flg_q    <= '0;
      valid_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        result_o <= res_d;
        flg_q    <= flg_d;
      end
    end
  end

  assign n_o = flg_q.n;
  assign z_o = flg_q.z;
  assign v_o = flg_q.v;
  assign c_o = flg_q.c;
endmodule

// File: rtl/bcd_addsub_alu_chk.sv
module bcd_addsub_alu_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              valid_i,
  input logic [1:0]        op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] m_i,
  input logic              carry_i,
  input logic              overflow_i,
  input logic [DATA_W-1:0] result_o,
  input logic              n_o,
  input logic              z_o,
  input logic              v_o,
  input logic              c_o,
  input logic              valid_o
);
  assert_valid_follows_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);

  assert_idle_no_valid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o);

  assert_idle_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(result_o) && $stable(c_o) && $stable(v_o)));

  assert_cmp_v_pass_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd2) |=> (v_o == $past(overflow_i)));

  assert_cmp_result_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd2) |=> (result_o == $past(a_i) && c_o == ($past(a_i) >= $past(m_i))));

  assert_arr_flags_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd3) |=>
      (c_o == result_o[DATA_W-2] && v_o == (result_o[DATA_W-2] ^ result_o[DATA_W-3])
       && n_o == result_o[DATA_W-1]));

  assert_add_zero_binary_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd0) |=>
      (z_o == (DATA_W'($past(a_i) + $past(m_i) + DATA_W'($past(carry_i))) == '0)));

  assert_sub_carry_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && op_i == 2'd1) |=>
      (c_o == ({1'b0, $past(a_i)} >= ({1'b0, $past(m_i)} + {{DATA_W{1'b0}}, ~$past(carry_i)}))));
endmodule

bind bcd_addsub_alu bcd_addsub_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .op_i       (op_i),
  .a_i        (a_i),
  .m_i        (m_i),
  .carry_i    (carry_i),
  .overflow_i (overflow_i),
  .result_o   (result_o),
  .n_o        (n_o),
  .z_o        (z_o),
  .v_o        (v_o),
  .c_o        (c_o),
  .valid_o    (valid_o)
);

// File: tb/bcd_addsub_alu_bench.sv
module bcd_addsub_alu_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       valid_i = 1'b0;
  logic [1:0] op_i = 2'd0;
  logic [7:0] a_i = '0;
  logic [7:0] m_i = '0;
  logic       carry_i = 1'b0;
  logic       decimal_i = 1'b0;
  logic       overflow_i = 1'b0;
  logic [7:0] result_o;
  logic       n_o, z_o, v_o, c_o, valid_o;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  typedef struct {
    logic [7:0] res;
    logic n, z, v, c;
    string tag;
  } exp_t;

  exp_t q[$];

  always #4 clk_i = ~clk_i;

  bcd_addsub_alu u_bcd_addsub_alu (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .op_i(op_i),
    .a_i(a_i), .m_i(m_i), .carry_i(carry_i), .decimal_i(decimal_i),
    .overflow_i(overflow_i), .result_o(result_o), .n_o(n_o), .z_o(z_o),
    .v_o(v_o), .c_o(c_o), .valid_o(valid_o)
  );

  function automatic exp_t model(input logic [1:0] op, input logic [7:0] a, input logic [7:0] m,
                                 input logic c, input logic d, input logic vin, input string tag);
    exp_t e;
    int s, lo, hi, dd, neg;
    logic [7:0] r8;
    e.tag = tag;
    case (op)
      2'd0: begin
        s = int'(a) + int'(m) + (c ? 1 : 0);
        r8 = s[7:0];
        e.n = r8[7];
        e.z = (r8 == 8'h00);
        if (d) begin
          lo = int'(a[3:0]) + int'(m[3:0]) + (c ? 1 : 0);
          if (lo > 9) lo += 6;
          hi = int'(a[7:4]) + int'(m[7:4]) + ((lo > 15) ? 1 : 0);
          e.v = (a[7] == m[7]) && (a[7] != hi[3]);
          if (hi > 9) hi += 6;
          e.c = (hi > 15);
          e.res = {hi[3:0], lo[3:0]};
        end else begin
          e.res = r8;
          e.v = (a[7] == m[7]) && (a[7] != r8[7]);
          e.c = s[8];
        end
      end
      2'd1: begin
        dd = int'(a) - int'(m) - (c ? 0 : 1);
        r8 = dd[7:0];
        e.n = r8[7];
        e.z = (r8 == 8'h00);
        e.c = (dd >= 0);
        e.v = (a[7] != m[7]) && (a[7] != r8[7]);
        e.res = r8;
        if (d) begin
          lo = int'(a[3:0]) - int'(m[3:0]) - (c ? 0 : 1);
          neg = (lo < 0) ? 1 : 0;
          if (neg != 0) lo -= 6;
          hi = int'(a[7:4]) - int'(m[7:4]) - neg;
          if (hi < 0) hi -= 6;
          e.res = {hi[3:0], lo[3:0]};
        end
      end
      2'd2: begin
        dd = int'(a) - int'(m);
        r8 = dd[7:0];
        e.res = a;
        e.n = r8[7];
        e.z = (r8 == 8'h00);
        e.c = (dd >= 0);
        e.v = vin;
      end
      default: begin
        r8 = {c, a[7:1] & m[7:1]};
        e.res = r8;
        e.n = r8[7];
        e.z = (r8 == 8'h00);
        e.c = r8[6];
        e.v = r8[6] ^ r8[5];
      end
    endcase
    return e;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [11:0] act, input logic [11:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got res=%h nzvc=%b expected res=%h nzvc=%b",
               tag, act[11:4], act[3:0], exp[11:4], exp[3:0]);
    end
  endtask

  task automatic send(input logic [1:0] op, input logic [7:0] a, input logic [7:0] m,
                      input logic c, input logic d, input logic vin, input string tag);
    @(negedge clk_i);
    valid_i = 1'b1;
    op_i = op; a_i = a; m_i = m; carry_i = c; decimal_i = d; overflow_i = vin;
    q.push_back(model(op, a, m, c, d, vin, tag));
  endtask

  // monitor / scoreboard
  always @(negedge clk_i) begin
    if (rst_ni && valid_o) begin
      if (q.size() == 0) begin
        check(1'b0, "R11 unexpected valid_o", {result_o, n_o, z_o, v_o, c_o}, 12'h000);
      end else begin
        exp_t e;
        e = q.pop_front();
        check({result_o, n_o, z_o, v_o, c_o} == {e.res, e.n, e.z, e.v, e.c}, e.tag,
              {result_o, n_o, z_o, v_o, c_o}, {e.res, e.n, e.z, e.v, e.c});
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] held;
    repeat (3) @(negedge clk_i);
    // R12 reset state
    check({result_o, n_o, z_o, v_o, c_o, valid_o} == 13'h0, "R12 reset",
          {result_o, n_o, z_o, v_o, c_o}, 12'h000);
    rst_ni = 1'b1;

    send(2'd0, 8'h50, 8'h50, 1'b0, 1'b0, 1'b0, "R1 R2 bin add overflow");
    send(2'd0, 8'hFF, 8'h01, 1'b0, 1'b0, 1'b0, "R1 R5 bin add wrap");
    send(2'd0, 8'h19, 8'h28, 1'b0, 1'b1, 1'b0, "R3 dec add low fix");
    send(2'd0, 8'h99, 8'h01, 1'b0, 1'b1, 1'b0, "R4 R5 dec add carry out Z binary");
    send(2'd0, 8'h50, 8'h30, 1'b0, 1'b1, 1'b0, "R4 dec add V before fix");
    send(2'd0, 8'h58, 8'h46, 1'b1, 1'b1, 1'b0, "R3 R4 dec add carry in");
    send(2'd1, 8'h50, 8'h10, 1'b1, 1'b0, 1'b0, "R6 bin sub");
    send(2'd1, 8'h50, 8'hB0, 1'b1, 1'b0, 1'b0, "R6 bin sub overflow");
    send(2'd1, 8'h00, 8'h00, 1'b0, 1'b0, 1'b0, "R6 bin sub borrow in");
    send(2'd1, 8'h42, 8'h15, 1'b1, 1'b1, 1'b0, "R7 R8 dec sub low fix");
    send(2'd1, 8'h00, 8'h01, 1'b1, 1'b1, 1'b0, "R7 R8 dec sub wrap");
    send(2'd1, 8'h80, 8'h01, 1'b1, 1'b1, 1'b0, "R8 dec sub V binary");
    send(2'd2, 8'h30, 8'h30, 1'b0, 1'b1, 1'b1, "R9 cmp equal decimal");
    send(2'd2, 8'h10, 8'h20, 1'b1, 1'b0, 1'b0, "R9 cmp less");
    send(2'd3, 8'hFF, 8'hC0, 1'b1, 1'b0, 1'b0, "R10 arr c6 v0");
    send(2'd3, 8'h81, 8'hFF, 1'b0, 1'b1, 1'b0, "R10 arr c6 v1");
    for (int i = 0; i < 24; i++) begin
      send(2'(i % 4), 8'(i * 37 + 3), 8'(i * 91 + 5), i[0], i[1], i[2],
           "sweep R1 R3 R6 R7 R9 R10");
    end

    // R11 idle cycles hold outputs
    @(negedge clk_i);
    valid_i = 1'b0;
    a_i = 8'h5A; m_i = 8'hA5; op_i = 2'd0; carry_i = 1'b1;
    @(negedge clk_i);
    held = result_o;
    @(negedge clk_i);
    @(negedge clk_i);
    check(result_o == held && !valid_o, "R11 idle hold",
          {result_o, 4'b0}, {held, 4'b0});
    check(q.size() == 0, "R11 all results delivered",
          {8'(q.size()), 4'b0}, 12'h000);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule